// File: doc/BRIEF.md
# CAN transmit mailbox status register

This block keeps the transmit status flags for every transmit mailbox of a CAN controller. Each mailbox has five flags. A completion flag is set when a transmission ends for any reason. A clean-completion flag is set when a transmission ends without error. Two more flags record arbitration loss and a transmit error. The fifth is a software stop request. The transmit engine reports its events as single-cycle pulses per mailbox. Software reads the flags and clears them through a single 32-bit register port.

The flags are write-1-to-clear and coupled to each other. Acknowledging the completion flag also removes the clean-completion, arbitration and error flags of that mailbox. The engine clears flags on its own as well: a new transmission start, a completion with error, and the mailbox going empty. Arming a mailbox for transmission (the transmit-enable request pulse) clears its completion flag.

Top module: `can_txstat_reg`

## Requirements
- R1: After a synchronous active-low reset every flag of every mailbox is 0 and the register reads 0x00000000.
- R2: Mailbox m occupies bits 8m to 8m+7 of the register. The offsets within that lane are: +0 completion, +1 clean completion, +2 arbitration lost, +3 transmit error, +7 stop request. Offsets +4 to +6 and every bit above the last mailbox read 0. The register sits at address STAT_ADDR (default 0), and reads at any other address return 0. Read data follows the address in the same cycle.
- R3: A done-ok, done-with-error or abort pulse for a mailbox sets its completion flag at the next clock edge.
- R4: The completion flag is cleared by writing 1 to its bit, or by a transmit-enable request pulse for that mailbox.
- R5: The clean-completion flag is set by a done-ok pulse. It is cleared by writing 1 to its own bit, by writing 1 to the completion bit, or by a done-with-error pulse.
- R6: The arbitration-lost and transmit-error flags are set by their event pulses. Each is cleared by writing 1 to its own bit, by writing 1 to the completion bit, or by a transmission-start pulse for that mailbox.
- R7: The stop request is set only by writing 1 to its bit and is cleared by a mailbox-empty pulse. If both arrive in the same cycle, the empty pulse wins and the bit ends at 0.
- R8: Writing 0 to any bit changes nothing, and writes to any address other than STAT_ADDR change nothing.
- R9: When a hardware set event and any clear reach the same flag in one cycle, the flag ends set.
- R10: Events and written bits for one mailbox never change the flags of another mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | REG_W | Write data, ones clear flags or set stop requests |
| bus_rdata | output | REG_W | Read data for bus_addr, combinational |
| ev_tx_start | input | NUM_MBOX | Transmission start pulse per mailbox |
| ev_tx_done_ok | input | NUM_MBOX | Transmission ended without error |
| ev_tx_done_err | input | NUM_MBOX | Transmission ended with an error |
| ev_tx_abort | input | NUM_MBOX | Transmission aborted |
| ev_arb_lost | input | NUM_MBOX | Arbitration lost |
| ev_tx_err | input | NUM_MBOX | Transmit error detected |
| ev_mbox_empty | input | NUM_MBOX | Mailbox became empty |
| sw_tx_en | input | NUM_MBOX | Software armed the mailbox for transmission |

## Verification
Each mailbox is driven in turn through the following patterns:
- Clean completion, then error completion. This separates the completion flag from the clean-completion flag.
- Acknowledgement of the clean-completion bit alone versus acknowledgement of the completion bit. This shows whether the coupled clear reaches the sibling flags.
- A start pulse, an abort with a re-arm pulse, and a mailbox-empty pulse. Each checks one hardware clear path.
- Same-cycle collisions of a set with a clear. These show whether set-priority holds for the flags and clear-priority holds for the stop request.
- Zero writes, writes to another address and an all-ones write. These separate real clears from ignored writes and expose any reserved bit that could be written.

Every result is compared as a whole register word, so a flag that moves in the wrong lane shows up as well.

// File: rtl/can_txstat_pkg.sv
// Package: shared lane layout and flag type for the CAN transmit status register.
// Assumes one 8-bit lane per mailbox; offsets below are decoded by software.
package can_txstat_pkg;
    localparam int LANE_W   = 8;
    localparam int FIN_BIT  = 0;
    localparam int OK_BIT   = 1;
    localparam int ARB_BIT  = 2;
    localparam int ERR_BIT  = 3;
    localparam int STOP_BIT = 7;

    typedef struct packed {
        logic stop;
        logic err;
        logic arb;
        logic ok;
        logic fin;
    } mbox_flags_t;
endpackage

// File: rtl/can_txstat_flag.sv
// Module: one status bit with a set input and a clear input.
// SET_WINS picks which input has priority when both are high in one cycle.
// Assumes synchronous active-low reset to 0.
module can_txstat_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;

    generate
        if (SET_WINS) begin : g_set_pri
            // Next state with the set input dominant.
            always_comb begin
                if (set_i)      q_d = 1'b1;
                else if (clr_i) q_d = 1'b0;
                else            q_d = q_o;
            end
        end else begin : g_clr_pri
            // Next state with the clear input dominant.
            always_comb begin
                if (clr_i)      q_d = 1'b0;
                else if (set_i) q_d = 1'b1;
                else            q_d = q_o;
            end
        end
    endgenerate

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_d;
    end
endmodule

// File: rtl/can_txstat_lane.sv
// Module: the five status flags of one transmit mailbox and their coupled rules.
// Assumes wr_* inputs are already qualified by a write hit on the status address.
module can_txstat_lane
    import can_txstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_start,
    input  logic        ev_done_ok,
    input  logic        ev_done_err,
    input  logic        ev_abort,
    input  logic        ev_arb,
    input  logic        ev_err,
    input  logic        ev_empty,
    input  logic        tx_en_req,
    input  logic        wr_fin,
    input  logic        wr_ok,
    input  logic        wr_arb,
    input  logic        wr_err,
    input  logic        wr_stop,
    output mbox_flags_t flags_o
);
    logic fin_set, fin_clr, ok_clr, arb_clr, err_clr;

    // Set and clear terms per flag; an acknowledged completion clears its siblings.
    always_comb begin
        fin_set = ev_done_ok | ev_done_err | ev_abort;
        fin_clr = wr_fin | tx_en_req;
        ok_clr  = wr_ok  | wr_fin | ev_done_err;
        arb_clr = wr_arb | wr_fin | ev_start;
        err_clr = wr_err | wr_fin | ev_start;
    end

    can_txstat_flag #(.SET_WINS(1'b1)) u_fin (
        .clk(clk), .rst_n(rst_n), .set_i(fin_set), .clr_i(fin_clr), .q_o(flags_o.fin));
    can_txstat_flag #(.SET_WINS(1'b1)) u_ok (
        .clk(clk), .rst_n(rst_n), .set_i(ev_done_ok), .clr_i(ok_clr), .q_o(flags_o.ok));
    can_txstat_flag #(.SET_WINS(1'b1)) u_arb (
        .clk(clk), .rst_n(rst_n), .set_i(ev_arb), .clr_i(arb_clr), .q_o(flags_o.arb));
    can_txstat_flag #(.SET_WINS(1'b1)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(ev_err), .clr_i(err_clr), .q_o(flags_o.err));
    // Stop request: a software set loses to the mailbox-empty clear.
    can_txstat_flag #(.SET_WINS(1'b0)) u_stop (
        .clk(clk), .rst_n(rst_n), .set_i(wr_stop), .clr_i(ev_empty), .q_o(flags_o.stop));
endmodule

// File: rtl/can_txstat_reg.sv
// Module: transmit status register for NUM_MBOX CAN transmit mailboxes.
// Single-cycle register port; reads are combinational, writes are write-1-to-clear
// for the flags and write-1-to-set for the stop requests.
// Assumes NUM_MBOX * LANE_W <= REG_W and single-cycle event pulses.
module can_txstat_reg
    import can_txstat_pkg::*;
#(
    parameter int               NUM_MBOX  = 3,
    parameter int               REG_W     = 32,
    parameter int               ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_MBOX-1:0] ev_tx_start,
    input  logic [NUM_MBOX-1:0] ev_tx_done_ok,
    input  logic [NUM_MBOX-1:0] ev_tx_done_err,
    input  logic [NUM_MBOX-1:0] ev_tx_abort,
    input  logic [NUM_MBOX-1:0] ev_arb_lost,
    input  logic [NUM_MBOX-1:0] ev_tx_err,
    input  logic [NUM_MBOX-1:0] ev_mbox_empty,
    input  logic [NUM_MBOX-1:0] sw_tx_en
);
    localparam int USED_W = NUM_MBOX * LANE_W;

    logic                   addr_hit;
    logic                   wr_hit;
    logic [REG_W-1:0]       stat_img;
    logic [NUM_MBOX-1:0][LANE_W-1:0] lane_img;

    // Address decode for read and write.
    always_comb begin
        addr_hit = (bus_addr == STAT_ADDR);
        wr_hit   = bus_we && addr_hit;
    end

    generate
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
            mbox_flags_t flags;
            logic [LANE_W-1:0] wr_lane;

            // Write lane of this mailbox, zero unless the status address is written.
            always_comb wr_lane = wr_hit ? bus_wdata[m*LANE_W +: LANE_W] : '0;

            can_txstat_lane u_lane (
                .clk        (clk),
                .rst_n      (rst_n),
                .ev_start   (ev_tx_start[m]),
                .ev_done_ok (ev_tx_done_ok[m]),
                .ev_done_err(ev_tx_done_err[m]),
                .ev_abort   (ev_tx_abort[m]),
                .ev_arb     (ev_arb_lost[m]),
                .ev_err     (ev_tx_err[m]),
                .ev_empty   (ev_mbox_empty[m]),
                .tx_en_req  (sw_tx_en[m]),
                .wr_fin     (wr_lane[FIN_BIT]),
                .wr_ok      (wr_lane[OK_BIT]),
                .wr_arb     (wr_lane[ARB_BIT]),
                .wr_err     (wr_lane[ERR_BIT]),
                .wr_stop    (wr_lane[STOP_BIT]),
                .flags_o    (flags)
            );

            // Place flags at their lane offsets; reserved offsets stay zero.
            always_comb begin
                lane_img[m]           = '0;
                lane_img[m][FIN_BIT]  = flags.fin;
                lane_img[m][OK_BIT]   = flags.ok;
                lane_img[m][ARB_BIT]  = flags.arb;
                lane_img[m][ERR_BIT]  = flags.err;
                lane_img[m][STOP_BIT] = flags.stop;
            end
        end
    endgenerate

    // Full register image; bits above the last mailbox read zero.
    always_comb begin
        stat_img             = '0;
        stat_img[USED_W-1:0] = lane_img;
    end

    // Read mux.
    always_comb bus_rdata = addr_hit ? stat_img : '0;
endmodule

// File: rtl/can_txstat_chk.sv
// Checker: temporal properties of the transmit status register, bound to the top.
// Assumes the status image is observed through the top's internal stat_img.
module can_txstat_chk #(
    parameter int               NUM_MBOX  = 3,
    parameter int               REG_W     = 32,
    parameter int               ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [NUM_MBOX-1:0] ev_tx_start,
    input logic [NUM_MBOX-1:0] ev_tx_done_ok,
    input logic [NUM_MBOX-1:0] ev_tx_done_err,
    input logic [NUM_MBOX-1:0] ev_tx_abort,
    input logic [NUM_MBOX-1:0] ev_arb_lost,
    input logic [NUM_MBOX-1:0] ev_tx_err,
    input logic [NUM_MBOX-1:0] ev_mbox_empty,
    input logic [NUM_MBOX-1:0] sw_tx_en,
    input logic [REG_W-1:0]    stat
);
    function automatic logic [REG_W-1:0] rsv_mask();
        logic [REG_W-1:0] mk;
        for (int b = 0; b < REG_W; b++) begin
            mk[b] = (b / 8 >= NUM_MBOX) || ((b % 8) >= 4 && (b % 8) <= 6);
        end
        return mk;
    endfunction

    localparam logic [REG_W-1:0] RSV = rsv_mask();

    logic any_ev;
    always_comb any_ev = |{ev_tx_start, ev_tx_done_ok, ev_tx_done_err, ev_tx_abort,
                           ev_arb_lost, ev_tx_err, ev_mbox_empty, sw_tx_en};

    // R2: reserved bits never read as one.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSV) == '0);

    // R8: an all-zero write with no events leaves the register unchanged.
    a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata == '0 && !any_ev) |=> $stable(stat));

    generate
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_chk
            // R3: any completion event sets the completion flag.
            a_r3_fin_set: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_tx_done_ok[m] || ev_tx_done_err[m] || ev_tx_abort[m]) |=> stat[8*m]);
            // R4: transmit-enable request clears completion when no set competes.
            a_r4_txen_clr: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_tx_en[m] && !ev_tx_done_ok[m] && !ev_tx_done_err[m] && !ev_tx_abort[m])
                |=> !stat[8*m]);
            // R5: error completion removes clean completion.
            a_r5_err_done_clr: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_tx_done_err[m] && !ev_tx_done_ok[m]) |=> !stat[8*m+1]);
            // R6: start clears arbitration and error flags.
            a_r6_start_clr: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_tx_start[m] && !ev_arb_lost[m] && !ev_tx_err[m])
                |=> (!stat[8*m+2] && !stat[8*m+3]));
            // R7: mailbox empty always removes the stop request.
            a_r7_empty_clr: assert property (@(posedge clk) disable iff (!rst_n)
                ev_mbox_empty[m] |=> !stat[8*m+7]);
            // R9: arbitration event wins over a coupled clear in the same cycle.
            a_r9_arb_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                ev_arb_lost[m] |=> stat[8*m+2]);
        end
    endgenerate
endmodule

bind can_txstat_reg can_txstat_chk #(
    .NUM_MBOX (NUM_MBOX),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .ev_tx_start   (ev_tx_start),
    .ev_tx_done_ok (ev_tx_done_ok),
    .ev_tx_done_err(ev_tx_done_err),
    .ev_tx_abort   (ev_tx_abort),
    .ev_arb_lost   (ev_arb_lost),
    .ev_tx_err     (ev_tx_err),
    .ev_mbox_empty (ev_mbox_empty),
    .sw_tx_en      (sw_tx_en),
    .stat          (stat_img)
);

// File: tb/tb_can_txstat_reg.sv
// Bench: scoreboard for the transmit status register. The driver applies one
// cycle of stimulus, computes the expected word from the requirements and queues
// it; the monitor pops and compares after each edge.
module tb_can_txstat_reg;
    localparam int NMB = 3;
    localparam logic [3:0] STAT  = 4'h0;
    localparam logic [3:0] OTHER = 4'h4;
    localparam logic [7:0] E_START = 8'h01, E_OK = 8'h02, E_DERR = 8'h04, E_ABORT = 8'h08,
                           E_ARB = 8'h10, E_ERR = 8'h20, E_EMPTY = 8'h40, E_TXEN = 8'h80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      bus_addr = STAT;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NMB-1:0]  ev_tx_start = '0, ev_tx_done_ok = '0, ev_tx_done_err = '0,
                     ev_tx_abort = '0, ev_arb_lost = '0, ev_tx_err = '0,
                     ev_mbox_empty = '0, sw_tx_en = '0;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    string       tag_q[$];
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    can_txstat_reg #(.NUM_MBOX(NMB), .REG_W(32), .ADDR_W(4), .STAT_ADDR(STAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx_start(ev_tx_start), .ev_tx_done_ok(ev_tx_done_ok),
        .ev_tx_done_err(ev_tx_done_err), .ev_tx_abort(ev_tx_abort),
        .ev_arb_lost(ev_arb_lost), .ev_tx_err(ev_tx_err),
        .ev_mbox_empty(ev_mbox_empty), .sw_tx_en(sw_tx_en));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Expected next word from the requirement rules (R3-R10).
    task automatic model_next(input int m, input logic [7:0] ev, input logic hit,
                              input logic [31:0] wd);
        logic [31:0] w;
        logic [31:0] nx;
        w  = hit ? wd : '0;
        nx = model;
        for (int k = 0; k < NMB; k++) begin
            logic [7:0] e;
            int b;
            e = (k == m) ? ev : 8'h00;
            b = 8 * k;
            nx[b]   = (e[1] | e[2] | e[3]) ? 1'b1 : ((w[b] | e[7]) ? 1'b0 : model[b]);
            nx[b+1] = e[1] ? 1'b1 : ((w[b+1] | w[b] | e[2]) ? 1'b0 : model[b+1]);
            nx[b+2] = e[4] ? 1'b1 : ((w[b+2] | w[b] | e[0]) ? 1'b0 : model[b+2]);
            nx[b+3] = e[5] ? 1'b1 : ((w[b+3] | w[b] | e[0]) ? 1'b0 : model[b+3]);
            nx[b+7] = e[6] ? 1'b0 : (w[b+7] ? 1'b1 : model[b+7]);
        end
        model = nx;
    endtask

    task automatic step(input string tag, input int m, input logic [7:0] ev,
                        input logic we, input logic [3:0] addr, input logic [31:0] wd);
        @(negedge clk);
        if (m >= 0) begin
            ev_tx_start[m]    = ev[0];
            ev_tx_done_ok[m]  = ev[1];
            ev_tx_done_err[m] = ev[2];
            ev_tx_abort[m]    = ev[3];
            ev_arb_lost[m]    = ev[4];
            ev_tx_err[m]      = ev[5];
            ev_mbox_empty[m]  = ev[6];
            sw_tx_en[m]       = ev[7];
        end
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        model_next(m, ev, we && (addr == STAT), wd);
        @(posedge clk);
        #1;
        ev_tx_start = '0; ev_tx_done_ok = '0; ev_tx_done_err = '0; ev_tx_abort = '0;
        ev_arb_lost = '0; ev_tx_err = '0; ev_mbox_empty = '0; sw_tx_en = '0;
        bus_we = 1'b0; bus_addr = STAT; bus_wdata = '0;
        tag_q.push_back(tag);
        exp_q.push_back(model);
    endtask

    // Monitor: compare queued expectations shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reads zero in reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle after reset", -1, 8'h00, 1'b0, STAT, '0);

        for (int m = 0; m < NMB; m++) begin
            int b;
            b = 8 * m;
            step("R3 R5 R10 done_ok sets fin and ok", m, E_OK, 1'b0, STAT, '0);
            step("R5 w1c ok alone", m, 8'h00, 1'b1, STAT, 32'h1 << (b + 1));
            step("R4 w1c fin", m, 8'h00, 1'b1, STAT, 32'h1 << b);
            step("R3 R5 done_ok again", m, E_OK, 1'b0, STAT, '0);
            step("R5 done_err clears ok", m, E_DERR, 1'b0, STAT, '0);
            step("R6 arb and err set", m, E_ARB | E_ERR, 1'b0, STAT, '0);
            step("R6 w1c fin clears arb err", m, 8'h00, 1'b1, STAT, 32'h1 << b);
            step("R6 arb and err set again", m, E_ARB | E_ERR, 1'b0, STAT, '0);
            step("R6 start clears arb err", m, E_START, 1'b0, STAT, '0);
            step("R6 arb and err set third", m, E_ARB | E_ERR, 1'b0, STAT, '0);
            step("R6 w1c arb alone", m, 8'h00, 1'b1, STAT, 32'h1 << (b + 2));
            step("R6 w1c err alone", m, 8'h00, 1'b1, STAT, 32'h1 << (b + 3));
            step("R3 abort sets fin", m, E_ABORT, 1'b0, STAT, '0);
            step("R4 tx enable clears fin", m, E_TXEN, 1'b0, STAT, '0);
            step("R9 done_ok beats w1c fin ok", m, E_OK, 1'b1, STAT,
                 (32'h1 << b) | (32'h1 << (b + 1)));
            step("R9 arb beats start", m, E_ARB | E_START, 1'b0, STAT, '0);
            step("R9 abort beats tx enable", m, E_ABORT | E_TXEN, 1'b0, STAT, '0);
            step("R7 stop set by write", m, 8'h00, 1'b1, STAT, 32'h1 << (b + 7));
            step("R8 zero write ignored", m, 8'h00, 1'b1, STAT, 32'h0);
            step("R8 other address write ignored", m, 8'h00, 1'b1, OTHER, 32'hFFFF_FFFF);
            step("R7 empty clears stop", m, E_EMPTY, 1'b0, STAT, '0);
            step("R7 empty beats stop write", m, E_EMPTY, 1'b1, STAT, 32'h1 << (b + 7));
            step("R10 leave arb set", m, E_ARB, 1'b0, STAT, '0);
        end

        step("R2 all-ones write", -1, 8'h00, 1'b1, STAT, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_addr = OTHER;
        #1;
        check("R2 other address reads zero", bus_rdata, 32'h0);
        bus_addr = STAT;
        step("R10 mailbox 1 events only", 1, E_OK | E_ARB | E_ERR, 1'b0, STAT, '0);
        step("R7 R10 empty on mailbox 2 only", 2, E_EMPTY, 1'b0, STAT, '0);

        repeat (3) @(posedge clk);
        #4;
        summary();
    end
endmodule